// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block holds the hazard decisions for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. The datapath feeds it three sets of register numbers:

- the two source registers of the instruction sitting in the decode latch;
- the two source registers of the instruction in the execute stage;
- the destination number, write enable and load flag of the three later pipeline latches.

From these it returns three kinds of result. The first is the operand bypass selects for both ALU inputs. The second is a one-cycle load-use stall. The third is the clear signals that kill the two younger instructions when a branch resolves as taken.

Forwarding covers three distances:

- **One instruction back:** the result is taken from the execute/memory latch.
- **Two instructions back:** the result is taken from the memory/writeback latch.
- **Three instructions back:** the block does nothing. The register file writes in the first half of the cycle and reads in the second, so the value is already current.

Branches are assumed not taken. When one is taken, the decode latch and the decode/execute latch are cleared. Clearing them zeroes the register-write and memory-access controls of the killed instructions, and this also applies to loads.

Top module: `hz_unit`

## Requirements
- R1: `dep_hits` carries the six decode-stage comparisons. Bit index is 2*stage + source. The stage index is 0 for the decode/execute latch, 1 for the execute/memory latch and 2 for the memory/writeback latch. The source index is 0 for `dec_rs` and 1 for `dec_rt`. A bit is 1 exactly when that latch's write enable is 1, its destination is nonzero and its destination equals that source.
- R2: A producer whose destination is register 0, or whose write enable is 0, never sets a `dep_hits` bit and is never selected for forwarding.
- R3: When an execute-stage source equals a live execute/memory destination, that operand's select (`fwd_a` for `ex_rs`, `fwd_b` for `ex_rt`) is 2'b10.
- R4: When an execute-stage source equals only a live memory/writeback destination, its select is 2'b01.
- R5: When both later latches match the same execute-stage source, the select is 2'b10, so the younger result wins.
- R6: With no live match the select is 2'b00 (register file). A decode source that matches only the memory/writeback destination causes no stall and no clear.
- R7: A load in the decode/execute latch whose live destination matches either decode source raises `pc_hold`, `ifid_hold` and `idex_clear`, while `ifid_clear` stays 0.
- R8: A matching non-load instruction in the decode/execute latch causes no hold and no clear.
- R9: When `br_taken` is 1, `ifid_clear` and `idex_clear` are 1 and both holds are 0, even if the load-use condition also holds.
- R10: Every output follows its inputs within the same cycle, with no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | RW | First source register of the decoding instruction |
| dec_rt | input | RW | Second source register of the decoding instruction |
| ex_rs | input | RW | First source register of the executing instruction |
| ex_rt | input | RW | Second source register of the executing instruction |
| idex_rd | input | RW | Destination held in the decode/execute latch |
| idex_wen | input | 1 | Register-write enable of the decode/execute latch |
| idex_mrd | input | 1 | Load flag of the decode/execute latch |
| exm_rd | input | RW | Destination held in the execute/memory latch |
| exm_wen | input | 1 | Register-write enable of the execute/memory latch |
| mwb_rd | input | RW | Destination held in the memory/writeback latch |
| mwb_wen | input | 1 | Register-write enable of the memory/writeback latch |
| br_taken | input | 1 | Branch in execute resolved taken |
| fwd_a | output | 2 | Bypass select for the first ALU operand |
| fwd_b | output | 2 | Bypass select for the second ALU operand |
| dep_hits | output | 6 | The six decode-stage comparison results |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode latch |
| idex_clear | output | 1 | Load a bubble into the decode/execute latch |
| ifid_clear | output | 1 | Kill the instruction in the fetch/decode latch |

## Verification
Every result of this block is due in the same cycle as the stimulus, because nothing on the path is registered. Each scenario task changes the inputs just after a falling clock edge. It waits one time unit for the logic to settle and then compares the whole output vector against an expected value computed from the requirements. No result is read across a clock edge, so process ordering at the edge cannot affect any check.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // operand bypass select codes
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;

  localparam int unsigned N_LATE_STG = 3; // decode/execute, execute/memory, memory/writeback
  localparam int unsigned N_SRC      = 2;
endpackage

// File: rtl/hz_cmp.sv
module hz_cmp #(
  parameter int unsigned RW   = 5,
  parameter int unsigned NSTG = 3,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0][RW-1:0] src,
  input  logic [NSTG-1:0][RW-1:0] dst,
  input  logic [NSTG-1:0]         wen,
  output logic [NSTG*NSRC-1:0]    hit
);
  // a live producer writing a nonzero register that a consumer reads
  function automatic logic dep(input logic [RW-1:0] d, input logic w,
                               input logic [RW-1:0] s);
    return w && (d != '0) && (d == s);
  endfunction

  for (genvar g_s = 0; g_s < NSTG; g_s++) begin : g_stg
    for (genvar g_o = 0; g_o < NSRC; g_o++) begin : g_src
      assign hit[g_s*NSRC + g_o] = dep(dst[g_s], wen[g_s], src[g_o]);
    end
  end
endmodule

// File: rtl/hz_fwd.sv
module hz_fwd
  import hz_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] exm_rd,
  input  logic          exm_wen,
  input  logic [RW-1:0] mwb_rd,
  input  logic          mwb_wen,
  output fwd_sel_e      sel,
  output logic          exm_hit,
  output logic          mwb_hit
);
  logic [1:0] hits;

  hz_cmp #(.RW(RW), .NSTG(2), .NSRC(1)) u_cmp (
    .src (src),
    .dst ({mwb_rd, exm_rd}),
    .wen ({mwb_wen, exm_wen}),
    .hit (hits)
  );

  assign exm_hit = hits[0];
  assign mwb_hit = hits[1];

  // younger result has priority
  always_comb begin
    if (exm_hit)      sel = FWD_EXM;
    else if (mwb_hit) sel = FWD_MWB;
    else              sel = FWD_RF;
  end
endmodule

// File: rtl/hz_ctl.sv
module hz_ctl (
  input  logic ld_use,
  input  logic br_taken,
  output logic pc_hold,
  output logic ifid_hold,
  output logic idex_clear,
  output logic ifid_clear
);
  logic stall_w;

  // a taken branch redirects fetch, so it overrides the stall
  assign stall_w    = ld_use && !br_taken;
  assign pc_hold    = stall_w;
  assign ifid_hold  = stall_w;
  assign ifid_clear = br_taken;
  assign idex_clear = stall_w || br_taken;
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic [RW-1:0] dec_rs,
  input  logic [RW-1:0] dec_rt,
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic [RW-1:0] idex_rd,
  input  logic          idex_wen,
  input  logic          idex_mrd,
  input  logic [RW-1:0] exm_rd,
  input  logic          exm_wen,
  input  logic [RW-1:0] mwb_rd,
  input  logic          mwb_wen,
  input  logic          br_taken,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic [5:0]    dep_hits,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_clear,
  output logic          ifid_clear
);
  localparam int unsigned NH = N_LATE_STG * N_SRC;

  logic [N_SRC-1:0][RW-1:0]      dec_src;
  logic [N_SRC-1:0][RW-1:0]      ex_src;
  logic [N_LATE_STG-1:0][RW-1:0] late_rd;
  logic [N_LATE_STG-1:0]         late_wen;
  logic [NH-1:0]                 hits_w;
  fwd_sel_e                      sel_w   [N_SRC];
  logic [N_SRC-1:0]              exm_hit_w;
  logic [N_SRC-1:0]              mwb_hit_w;
  logic                          ld_use_w;

  assign dec_src  = {dec_rt, dec_rs};
  assign ex_src   = {ex_rt, ex_rs};
  assign late_rd  = {mwb_rd, exm_rd, idex_rd};
  assign late_wen = {mwb_wen, exm_wen, idex_wen};

  hz_cmp #(.RW(RW), .NSTG(N_LATE_STG), .NSRC(N_SRC)) u_dec_cmp (
    .src (dec_src),
    .dst (late_rd),
    .wen (late_wen),
    .hit (hits_w)
  );

  for (genvar g_op = 0; g_op < N_SRC; g_op++) begin : g_op_fwd
    hz_fwd #(.RW(RW)) u_fwd (
      .src     (ex_src[g_op]),
      .exm_rd  (exm_rd),
      .exm_wen (exm_wen),
      .mwb_rd  (mwb_rd),
      .mwb_wen (mwb_wen),
      .sel     (sel_w[g_op]),
      .exm_hit (exm_hit_w[g_op]),
      .mwb_hit (mwb_hit_w[g_op])
    );
  end

  // only the decode/execute comparisons can need a stall
  assign ld_use_w = idex_mrd && (|hits_w[N_SRC-1:0]);

  hz_ctl u_ctl (
    .ld_use     (ld_use_w),
    .br_taken   (br_taken),
    .pc_hold    (pc_hold),
    .ifid_hold  (ifid_hold),
    .idex_clear (idex_clear),
    .ifid_clear (ifid_clear)
  );

  assign fwd_a    = sel_w[0];
  assign fwd_b    = sel_w[1];
  assign dep_hits = hits_w;
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
  parameter int unsigned RW = 5
) (
  input logic [RW-1:0] ex_rs,
  input logic [RW-1:0] exm_rd,
  input logic          exm_wen,
  input logic [RW-1:0] mwb_rd,
  input logic          mwb_wen,
  input logic          br_taken,
  input logic [1:0]    fwd_a,
  input logic [5:0]    dep_hits,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          idex_clear,
  input logic          ifid_clear,
  input logic [1:0]    exm_hit_w,
  input logic          ld_use_w
);
  always_comb begin
    // R2
    exm_zero_chk: assert (!(fwd_a == 2'b10) || (exm_wen && exm_rd != '0 && exm_rd == ex_rs));
    // R4
    mwb_src_chk: assert (!(fwd_a == 2'b01) || (mwb_wen && mwb_rd != '0 && mwb_rd == ex_rs));
    // R5
    exm_prio_chk: assert (!exm_hit_w[0] || fwd_a == 2'b10);
    // R7
    hold_pair_chk: assert (pc_hold == ifid_hold);
    // R7
    stall_bubble_chk: assert (!pc_hold || (idex_clear && !ifid_clear));
    // R9
    branch_kill_chk: assert (!br_taken || (ifid_clear && idex_clear && !pc_hold));
    // R8
    stall_cause_chk: assert (!pc_hold || (ld_use_w && |dep_hits[1:0]));
  end
endmodule

bind hz_unit hz_unit_chk #(.RW(RW)) u_hz_unit_chk (
  .ex_rs      (ex_rs),
  .exm_rd     (exm_rd),
  .exm_wen    (exm_wen),
  .mwb_rd     (mwb_rd),
  .mwb_wen    (mwb_wen),
  .br_taken   (br_taken),
  .fwd_a      (fwd_a),
  .dep_hits   (dep_hits),
  .pc_hold    (pc_hold),
  .ifid_hold  (ifid_hold),
  .idex_clear (idex_clear),
  .ifid_clear (ifid_clear),
  .exm_hit_w  (exm_hit_w),
  .ld_use_w   (ld_use_w)
);

// File: tb/hz_unit_bench.sv
module hz_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [RW-1:0] dec_rs, dec_rt, ex_rs, ex_rt, idex_rd, exm_rd, mwb_rd;
  logic idex_wen, idex_mrd, exm_wen, mwb_wen, br_taken;
  logic [1:0] fwd_a, fwd_b;
  logic [5:0] dep_hits;
  logic pc_hold, ifid_hold, idex_clear, ifid_clear;

  int n_chk = 0;
  int n_bad = 0;

  hz_unit #(.RW(RW)) u_hz_unit (.*);

  // expected values written from the requirement text
  function automatic logic live(input logic [RW-1:0] d, input logic w, input logic [RW-1:0] s);
    if (!w) return 1'b0;
    if (d == 0) return 1'b0;
    return d == s;
  endfunction

  function automatic logic [1:0] want_sel(input logic [RW-1:0] s);
    if (live(exm_rd, exm_wen, s)) return 2'b10;
    if (live(mwb_rd, mwb_wen, s)) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [13:0] want_all();
    logic [5:0] d;
    logic lu;
    d = {live(mwb_rd, mwb_wen, dec_rt), live(mwb_rd, mwb_wen, dec_rs),
         live(exm_rd, exm_wen, dec_rt), live(exm_rd, exm_wen, dec_rs),
         live(idex_rd, idex_wen, dec_rt), live(idex_rd, idex_wen, dec_rs)};
    lu = idex_mrd & (d[0] | d[1]);
    if (br_taken)
      return {want_sel(ex_rs), want_sel(ex_rt), d, 1'b0, 1'b0, 1'b1, 1'b1};
    return {want_sel(ex_rs), want_sel(ex_rt), d, lu, lu, lu, 1'b0};
  endfunction

  task automatic drive(input logic [RW-1:0] a, b, c, e, ir, input logic iw, im,
                       input logic [RW-1:0] er, input logic ew,
                       input logic [RW-1:0] mr, input logic mw, input logic bt);
    @(negedge clk);
    dec_rs = a; dec_rt = b; ex_rs = c; ex_rt = e;
    idex_rd = ir; idex_wen = iw; idex_mrd = im;
    exm_rd = er; exm_wen = ew; mwb_rd = mr; mwb_wen = mw; br_taken = bt;
    #1;
  endtask

  task automatic check(input string tag, input logic [13:0] exp);
    logic [13:0] act;
    act = {fwd_a, fwd_b, dep_hits, pc_hold, ifid_hold, idex_clear, ifid_clear};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic t_idle();   // R10 idle state
    drive(0,0,0,0,0,0,0,0,0,0,0,0);
    check("R10 idle", 14'b0);
  endtask

  task automatic t_one_back();   // R3
    drive(1,2,7,8,0,0,0,7,1,0,0,0);
    check("R3 exm to a", {2'b10, 2'b00, 6'b0, 4'b0});
    drive(1,2,3,9,0,0,0,9,1,0,0,0);
    check("R3 exm to b", {2'b00, 2'b10, 6'b0, 4'b0});
  endtask

  task automatic t_two_back();   // R4
    drive(1,2,4,5,0,0,0,0,0,5,1,0);
    check("R4 mwb to b", {2'b00, 2'b01, 6'b0, 4'b0});
  endtask

  task automatic t_both();   // R5
    drive(1,2,6,6,0,0,0,6,1,6,1,0);
    check("R5 younger wins", {2'b10, 2'b10, 6'b0, 4'b0});
  endtask

  task automatic t_zero_off();   // R2
    drive(0,0,0,0,0,1,1,0,1,0,1,0);
    check("R2 reg zero", 14'b0);
    drive(3,3,3,3,3,0,1,3,0,3,0,0);
    check("R2 wen off", 14'b0);
  endtask

  task automatic t_three_back();   // R6
    drive(11,12,1,2,0,0,0,0,0,12,1,0);
    check("R6 mwb decode only", want_all());
    check("R6 no stall", {2'b00, 2'b00, 6'b100000, 4'b0});
  endtask

  task automatic t_load_use();   // R7
    drive(4,5,0,0,4,1,1,0,0,0,0,0);
    check("R7 load rs", {4'b0, 6'b000001, 4'b1110});
    drive(4,5,0,0,5,1,1,0,0,0,0,0);
    check("R7 load rt", {4'b0, 6'b000010, 4'b1110});
  endtask

  task automatic t_non_load();   // R8
    drive(4,5,0,0,5,1,0,0,0,0,0,0);
    check("R8 alu producer", {4'b0, 6'b000010, 4'b0000});
  endtask

  task automatic t_branch();   // R9
    drive(1,2,0,0,0,0,0,0,0,0,0,1);
    check("R9 taken", {10'b0, 4'b0011});
    drive(4,5,0,0,4,1,1,0,0,0,0,1);
    check("R9 taken over load", {4'b0, 6'b000001, 4'b0011});
  endtask

  task automatic t_map();   // R1
    drive(7,9,0,0,9,1,0,7,1,9,1,0);
    check("R1 map", {4'b0, 6'b100110, 4'b0});
    for (int k = 1; k < 32; k += 5) begin
      drive(k[4:0], 5'(31-k), k[4:0], 5'(31-k), k[4:0], 1, k[0],
            5'(31-k), 1, k[4:0], 1, 0);
      check("R1 sweep", want_all());
    end
  endtask

  initial begin
    t_idle();
    t_one_back();
    t_two_back();
    t_both();
    t_zero_off();
    t_three_back();
    t_load_use();
    t_non_load();
    t_branch();
    t_map();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule